// File: doc/BRIEF.md
# Reference Clock Rate Monitor

The block runs in the system clock domain and watches a free-running external reference clock. It brings the reference in through a synchronizer and detects its rising edges. It then counts prescaled system-clock ticks over a window of 32 reference periods. At the close of each window the tick count is latched as a measurement and the running counter restarts.

Two checks run side by side. The latched measurement is compared against a programmed lower bound. The live running count is compared against a programmed upper bound at every cycle, so a reference that stops entirely still trips the monitor even though no further measurement is ever latched. Either violation sets a sticky failure flag, which drives an interrupt and a mute request until software clears it.

Configuration uses one 32-bit control word, written through a simple write strobe and always visible on a read-back bus.

Top module: `clk_rate_mon`

## Requirements
- R1: A window spans 32 synchronized rising edges of `ref_clk_i`. On the 32nd edge the running count is copied into the measured field and the running counter is cleared in the same cycle. With divide-by-1 and reference edges exactly P system cycles apart, the measured value is 32*P-1.
- R2: Prescale code k in the range 0 to 8 (control bits [3:0]) advances the running counter once every 2^k system cycles.
- R3: Prescale codes 9 to 15 divide by 256, the same as code 8.
- R4: The running counter saturates at 255 and does not wrap, so a window longer than 255 ticks measures 255.
- R5: A lower-bound violation exists when the measured value is less than the lower bound (unsigned). It is evaluated only once at least one window has completed since reset.
- R6: An upper-bound violation exists in any cycle in which the running count is greater than the upper bound (unsigned). A stopped reference therefore raises it once the count passes the bound.
- R7: Either violation sets the failure flag. The flag stays set after the violation goes away, and `irq_o` and `mute_o` are both high whenever the flag is set.
- R8: A pulse on `fail_clr_i` clears the flag. If a violation is present in the same cycle, the flag stays set.
- R9: The control word holds the prescale code in bits [3:0], the lower bound in [15:8] and the upper bound in [23:16]. Read-back shows these fields, zeros in [7:4], and the measured value in [31:24]. Writes to [31:24] and [7:4] have no effect. The reset value is 0x00FF0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | External reference clock, asynchronous |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_wdata_i | input | 32 | Control word write data |
| cfg_rdata_o | output | 32 | Control word read-back including measured value |
| fail_clr_i | input | 1 | Write-one-to-clear for the failure flag |
| fail_o | output | 1 | Sticky failure status |
| irq_o | output | 1 | Interrupt request |
| mute_o | output | 1 | Mute request |

## Verification
The bench builds the block with its default parameters: an 8-bit count, a 4-bit prescale code, a 32-edge window and a two-stage synchronizer. With these values, reference half-periods of 2, 3 and 5 system cycles give exact measurements of 127 and 191 and a saturated 255. A half-period of 128 cycles brings the divide-by-256 codes into a window of 8192 cycles. Keeping the reference aligned to the system clock makes the divide-by-1 measurements exact. The divided cases are checked within a one-tick tolerance, which covers prescaler phase.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  localparam int unsigned CNT_W     = 8;
  localparam int unsigned PS_W      = 4;
  localparam int unsigned PS_MAXLOG = 8;
  localparam int unsigned WIN_EDGES = 32;
  localparam int unsigned SYNC_N    = 2;

  typedef struct packed {
    logic [CNT_W-1:0] hi_bound;
    logic [CNT_W-1:0] lo_bound;
    logic [PS_W-1:0]  ps_sel;
  } cfm_cfg_t;
endpackage

// File: rtl/cfm_sync.sv
module cfm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  p_rise_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/cfm_prescale.sv
module cfm_prescale #(
  parameter int unsigned PS_W   = 4,
  parameter int unsigned MAXLOG = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PS_W-1:0] sel_i,
  output logic            tick_o
);
  logic [MAXLOG-1:0] div_q;
  logic [MAXLOG-1:0] lim;
  logic [PS_W-1:0]   lg;

  // codes beyond the largest divider clamp to it
  always_comb begin
    lg  = (sel_i > PS_W'(MAXLOG)) ? PS_W'(MAXLOG) : sel_i;
    lim = {MAXLOG{1'b1}} >> (PS_W'(MAXLOG) - lg);
  end

  assign tick_o = (div_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  p_div_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_o && $stable(sel_i)) |=> (div_q != '0));
endmodule

// File: rtl/cfm_window.sv
module cfm_window #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned EDGES = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] run_cnt_o,
  output logic [CNT_W-1:0] meas_o,
  output logic             meas_vld_o,
  output logic             win_end_o
);
  localparam int unsigned EW = (EDGES > 1) ? $clog2(EDGES) : 1;

  logic [EW-1:0]    edge_q;
  logic [CNT_W-1:0] run_q, meas_q;
  logic             vld_q;

  assign win_end_o = rise_i && (edge_q == EW'(EDGES-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q <= '0;
      run_q  <= '0;
      meas_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      if (win_end_o)   edge_q <= '0;
      else if (rise_i) edge_q <= edge_q + 1'b1;

      if (win_end_o) begin
        meas_q <= run_q;
        vld_q  <= 1'b1;
        run_q  <= '0;
      end else if (tick_i && run_q != '1) begin
        run_q <= run_q + 1'b1; // saturate, stopped clock keeps max check live
      end
    end
  end

  assign run_cnt_o  = run_q;
  assign meas_o     = meas_q;
  assign meas_vld_o = vld_q;

  p_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q == '1 && !win_end_o) |=> (run_q == '1));
  p_meas_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end_o |=> $stable(meas_q));
  p_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end_o |=> (run_q == '0));
endmodule

// File: rtl/clk_rate_mon.sv
module clk_rate_mon
  import cfm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ref_clk_i,
  input  logic        cfg_we_i,
  input  logic [31:0] cfg_wdata_i,
  output logic [31:0] cfg_rdata_o,
  input  logic        fail_clr_i,
  output logic        fail_o,
  output logic        irq_o,
  output logic        mute_o
);
  cfm_cfg_t         cfg_q;
  logic             rise, tick, win_end, meas_vld;
  logic [CNT_W-1:0] run_cnt, meas;
  logic             lo_viol, hi_viol, viol, fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.ps_sel   <= '0;
      cfg_q.lo_bound <= '0;
      cfg_q.hi_bound <= '1;
    end else if (cfg_we_i) begin
      cfg_q.ps_sel   <= cfg_wdata_i[3:0];
      cfg_q.lo_bound <= cfg_wdata_i[15:8];
      cfg_q.hi_bound <= cfg_wdata_i[23:16];
    end
  end

  cfm_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(ref_clk_i), .rise_o(rise));

  cfm_prescale #(.PS_W(PS_W), .MAXLOG(PS_MAXLOG)) u_ps (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(cfg_q.ps_sel), .tick_o(tick));

  cfm_window #(.CNT_W(CNT_W), .EDGES(WIN_EDGES)) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .tick_i(tick),
    .run_cnt_o(run_cnt), .meas_o(meas), .meas_vld_o(meas_vld),
    .win_end_o(win_end));

  assign lo_viol = meas_vld && (meas < cfg_q.lo_bound);
  assign hi_viol = (run_cnt > cfg_q.hi_bound);
  assign viol    = lo_viol | hi_viol;

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fail_q <= 1'b0;
    else         fail_q <= viol | (fail_q & ~fail_clr_i);
  end

  assign cfg_rdata_o = {meas, cfg_q.hi_bound, cfg_q.lo_bound, 4'b0, cfg_q.ps_sel};
  assign fail_o      = fail_q;
  assign irq_o       = fail_q;
  assign mute_o      = fail_q;

  p_hi_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_cnt > cfg_q.hi_bound) |=> fail_q);
  p_lo_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_vld && meas < cfg_q.lo_bound) |=> fail_q);
  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q && !fail_clr_i) |=> fail_q);
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_clr_i && !viol) |=> !fail_q);
endmodule

// File: tb/clk_rate_mon_test.sv
module clk_rate_mon_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_clk = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        fail_clr = 1'b0;
  logic        fail, irq, mute;

  int checks = 0;
  int failures = 0;
  int ref_half = 2;
  int ph = 0;
  bit ref_run = 1'b0;

  clk_rate_mon uut (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .fail_clr_i(fail_clr), .fail_o(fail), .irq_o(irq), .mute_o(mute));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (ref_run) begin
      if (ph >= ref_half - 1) begin ref_clk <= ~ref_clk; ph <= 0; end
      else ph <= ph + 1;
    end
  end

  // sel, half-period, expected low, expected high of measured value
  localparam int NV = 9;
  localparam int VSEL [NV] = '{0, 0, 0, 1, 2, 3, 0, 8, 12};
  localparam int VHALF[NV] = '{2, 3, 4, 2, 4, 8, 5, 128, 128};
  localparam int VLO  [NV] = '{127, 191, 255, 63, 63, 63, 255, 31, 31};
  localparam int VHI  [NV] = '{127, 191, 255, 64, 64, 64, 255, 32, 32};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] lo,
                     input logic [31:0] hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr_cfg(input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic clr_pulse();
    @(negedge clk); fail_clr = 1'b1;
    @(negedge clk); fail_clr = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_900_000;
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    // R9 reset value
    chk("R9 reset rdata", cfg_rdata, 32'h00FF0000, 32'h00FF0000);
    chk("R7 reset fail", {29'b0, fail, irq, mute}, 0, 0);

    // R5: no lower-bound check before the first window; ref stopped
    wr_cfg(32'h00FFFF00);
    wait_cyc(400);
    chk("R5 no check before first window", fail, 0, 0);
    wr_cfg(32'h00FF0000);

    ref_run = 1'b1;
    for (int i = 0; i < NV; i++) begin
      ref_half = VHALF[i];
      wr_cfg({8'h00, 8'hFF, 8'h00, 4'h0, 4'(VSEL[i])});
      wait_cyc(3 * 64 * VHALF[i] + 20);
      chk(VSEL[i] > 8 ? "R3 clamp measure" : (VSEL[i] > 0 ? "R2 divide measure" :
          (VHALF[i] >= 4 ? "R4 saturate measure" : "R1 window measure")),
          {24'b0, cfg_rdata[31:24]}, VLO[i], VHI[i]);
      chk("R7 no fail in range", fail, 0, 0);
    end

    // R9: read-only and reserved bits ignored
    ref_half = 2;
    wr_cfg(32'h00FF0000);
    wait_cyc(3 * 128 + 20);
    wr_cfg(32'hA5FF00F0);
    wait_cyc(2);
    chk("R9 ignored bits", cfg_rdata, 32'h7FFF0000, 32'h7FFF0000);

    // R5: lower bound 128 above measured 127
    wr_cfg(32'h00FF8000);
    wait_cyc(140);
    chk("R5 lo violation", fail, 1, 1);
    chk("R7 irq/mute follow", {30'b0, irq, mute}, 3, 3);
    // R7: sticky after violation gone
    wr_cfg(32'h00FF7F00);
    wait_cyc(300);
    chk("R7 sticky", fail, 1, 1);
    clr_pulse();
    wait_cyc(2);
    chk("R8 clear", {29'b0, fail, irq, mute}, 0, 0);

    // R6: upper bound below live count
    wr_cfg(32'h00640000);
    wait_cyc(140);
    chk("R6 hi violation live", fail, 1, 1);
    wr_cfg(32'h00FF0000);
    clr_pulse();
    wait_cyc(2);
    chk("R8 clear after hi", fail, 0, 0);

    // R6: stopped reference
    wr_cfg(32'h00C80000);
    clr_pulse();
    ref_run = 1'b0;
    wait_cyc(10);
    chk("R8 clear before stop effect", fail, 0, 0);
    wait_cyc(300);
    chk("R6 stopped ref caught", fail, 1, 1);
    chk("R1 meas held when stopped", {24'b0, cfg_rdata[31:24]}, 127, 127);
    clr_pulse();
    wait_cyc(2);
    chk("R8 set beats clear", fail, 1, 1);
    wr_cfg(32'h00FF0000);
    clr_pulse();
    wait_cyc(5);
    chk("R4 saturated not above 255", fail, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule